// File: doc/BRIEF.md
# Multi-Mode Receive Output Formatter

This block sits behind a receive word aligner. For each aligned 10-bit word marked by a one-cycle strobe, it drives a parallel output bus and two byte clocks. Both byte clocks are registered outputs built on a fast internal clock grid of `WORD_TICKS` ticks per word, so the block has no derived clocks inside it. Two static pins choose the output timing.

The timing choices are:
- **Full-rate 10-bit:** one byte clock runs at the word rate.
- **Half-rate 10-bit:** two byte clocks run at half the word rate. Successive words are steered alternately to the two clocks.
- **Reduced 5-bit double-data-rate:** each word leaves as two 5-bit halves, one per edge of a word-rate clock.

Output data always changes half a clock period (or half a half-period, in the double-data-rate mode) away from the edge that samples it. When the aligner shifts the word boundary, the next strobe arrives late. The clocks and data then simply hold their current level, so no high or low phase is ever cut short.

Top module: `rx_out_formatter`

## Requirements
- R1: After reset, `rx_data`, `bclk0` and `bclk1` are all low, and both clocks stay low until the first word strobe.
- R2: With `ddr_sel`=0 and `clk_sel`=1 (full-rate), `rx_data` takes the strobed word at the strobe edge. `bclk0` rises `WORD_TICKS/2` ticks later and stays high until the next strobe. `bclk1` stays low.
- R3: With `ddr_sel`=0 and `clk_sel`=0 (half-rate), words are counted from 0 starting at the first strobe after reset. For an even-numbered word, `bclk1` rises `WORD_TICKS/2` ticks after its strobe and `bclk0` falls at that same tick. For an odd-numbered word, `bclk0` rises and `bclk1` falls at that tick. Before that tick, both clocks hold their levels. `rx_data` carries the full word from its strobe edge.
- R4: With `ddr_sel`=1, `rx_data[9:5]` is always 0. `rx_data[4:0]` carries word bits 4..0 for the first `WORD_TICKS/2` ticks after the strobe, and word bits 9..5 from then on.
- R5: With `ddr_sel`=1, `bclk0` is high from `WORD_TICKS/4` to `3*WORD_TICKS/4`-1 ticks after each strobe, and `bclk1` stays low. The level of `clk_sel` has no effect in this mode.
- R6: When the gap between strobes is longer than `WORD_TICKS`, every output keeps the level it reached at tick `WORD_TICKS`-1 until the next strobe. As a result, no clock phase is shorter than nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast grid clock, `WORD_TICKS` ticks per word |
| rst | input | 1 | Synchronous active-high reset |
| ddr_sel | input | 1 | Static: 1 selects 5-bit double-data-rate output |
| clk_sel | input | 1 | Static: with `ddr_sel`=0, 1 selects full-rate and 0 selects half-rate |
| word_stb | input | 1 | One-cycle strobe marking a new aligned word; strobes are at least `WORD_TICKS` apart |
| word_in | input | WORD_W | Aligned receive word, valid with `word_stb` |
| rx_data | output | WORD_W | Registered parallel receive data |
| bclk0 | output | 1 | Registered byte clock 0 |
| bclk1 | output | 1 | Registered byte clock 1 (half-rate mode only) |

## Verification
A phase counter that drifts from the strobe moves the clock edges relative to the data. This shows within one word period as an edge landing on a data change, and the stable-data-at-edge properties catch it there. A lost half-rate word parity swaps the clock that captures each word. The first strobe after reset then exposes it: `bclk1` must be the first clock to rise. A wrong half-select in the double-data-rate mode puts the upper five bits out in the first half-word. That appears `WORD_TICKS/2` ticks early on `rx_data[4:0]`.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;
  typedef enum logic [1:0] {
    FMT_HALF = 2'd0,
    FMT_FULL = 2'd1,
    FMT_DDR  = 2'd2
  } fmt_e;

  function automatic fmt_e fmt_decode(input logic ddr_sel, input logic clk_sel);
    if (ddr_sel)      return FMT_DDR;
    else if (clk_sel) return FMT_FULL;
    else              return FMT_HALF;
  endfunction
endpackage

// File: rtl/rxfmt_phase.sv
// Tick counter since the last strobe, saturating (stretch), plus word parity.
module rxfmt_phase #(
  parameter int WORD_TICKS = 8,
  localparam int CNT_W = $clog2(WORD_TICKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  output logic [CNT_W-1:0] cnt_n,
  output logic             par_n,
  output logic             seen_n
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             par_q;
  logic             seen_q;

  always_comb begin
    if (stb)                cnt_n = '0;
    else if (cnt_q == LAST) cnt_n = cnt_q;
    else                    cnt_n = cnt_q + 1'b1;
    par_n  = stb ? ~par_q : par_q;
    seen_n = seen_q | stb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= LAST;
      par_q  <= 1'b1;   // first strobe makes word index 0
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      par_q  <= par_n;
      seen_q <= seen_n;
    end
  end
endmodule

// File: rtl/rxfmt_clkgen.sv
// Registered byte clocks derived from the phase count.
module rxfmt_clkgen
  import rxfmt_pkg::*;
#(
  parameter int WORD_TICKS = 8,
  localparam int CNT_W = $clog2(WORD_TICKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  fmt_e             fmt,
  input  logic [CNT_W-1:0] cnt_n,
  input  logic             par_n,
  input  logic             seen_n,
  output logic             bclk0,
  output logic             bclk1
);
  localparam logic [CNT_W-1:0] HALF_T = CNT_W'(WORD_TICKS / 2);
  localparam logic [CNT_W-1:0] Q1_T   = CNT_W'(WORD_TICKS / 4);
  localparam logic [CNT_W-1:0] Q3_T   = CNT_W'(3 * WORD_TICKS / 4);

  logic past_half;
  logic in_ddr_hi;

  always_comb begin
    past_half = seen_n && (cnt_n >= HALF_T);
    in_ddr_hi = seen_n && (cnt_n >= Q1_T) && (cnt_n < Q3_T);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk0 <= 1'b0;
      bclk1 <= 1'b0;
    end else begin
      unique case (fmt)
        FMT_FULL: begin
          bclk0 <= past_half;
          bclk1 <= 1'b0;
        end
        FMT_DDR: begin
          bclk0 <= in_ddr_hi;
          bclk1 <= 1'b0;
        end
        default: begin
          if (past_half) begin
            bclk1 <= ~par_n;
            bclk0 <= par_n;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rxfmt_datapath.sv
// Word hold register and output mux (full word or 5-bit half).
module rxfmt_datapath
  import rxfmt_pkg::*;
#(
  parameter int WORD_W     = 10,
  parameter int WORD_TICKS = 8,
  localparam int CNT_W  = $clog2(WORD_TICKS),
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  fmt_e              fmt,
  input  logic              stb,
  input  logic [WORD_W-1:0] word_in,
  input  logic [CNT_W-1:0]  cnt_n,
  output logic [WORD_W-1:0] rx_data
);
  localparam logic [CNT_W-1:0] HALF_T = CNT_W'(WORD_TICKS / 2);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_n;
  logic [WORD_W-1:0] out_n;

  always_comb begin
    word_n = stb ? word_in : word_q;
    if (fmt == FMT_DDR) begin
      out_n = '0;
      out_n[HALF_W-1:0] = (cnt_n < HALF_T) ? word_n[HALF_W-1:0]
                                           : word_n[WORD_W-1:HALF_W];
    end else begin
      out_n = word_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      rx_data <= '0;
    end else begin
      word_q  <= word_n;
      rx_data <= out_n;
    end
  end
endmodule

// File: rtl/rx_out_formatter.sv
module rx_out_formatter
  import rxfmt_pkg::*;
#(
  parameter int WORD_W     = 10,
  parameter int WORD_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ddr_sel,
  input  logic              clk_sel,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] rx_data,
  output logic              bclk0,
  output logic              bclk1
);
  localparam int CNT_W = $clog2(WORD_TICKS);

  initial begin
    if (WORD_TICKS < 4 || (WORD_TICKS % 4) != 0)
      $error("WORD_TICKS must be a multiple of 4, at least 4");
    if ((WORD_W % 2) != 0)
      $error("WORD_W must be even");
  end

  fmt_e             fmt;
  logic [CNT_W-1:0] cnt_n;
  logic             par_n;
  logic             seen_n;

  assign fmt = fmt_decode(ddr_sel, clk_sel);

  rxfmt_phase #(.WORD_TICKS(WORD_TICKS)) u_phase (
    .clk(clk), .rst(rst), .stb(word_stb),
    .cnt_n(cnt_n), .par_n(par_n), .seen_n(seen_n)
  );

  rxfmt_clkgen #(.WORD_TICKS(WORD_TICKS)) u_clkgen (
    .clk(clk), .rst(rst), .fmt(fmt),
    .cnt_n(cnt_n), .par_n(par_n), .seen_n(seen_n),
    .bclk0(bclk0), .bclk1(bclk1)
  );

  rxfmt_datapath #(.WORD_W(WORD_W), .WORD_TICKS(WORD_TICKS)) u_data (
    .clk(clk), .rst(rst), .fmt(fmt), .stb(word_stb),
    .word_in(word_in), .cnt_n(cnt_n), .rx_data(rx_data)
  );
endmodule

// File: rtl/rxfmt_chk.sv
module rxfmt_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              ddr_sel,
  input logic              clk_sel,
  input logic [WORD_W-1:0] rx_data,
  input logic              bclk0,
  input logic              bclk1
);
  localparam int HALF_W = WORD_W / 2;

  AST_DDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ddr_sel |=> (rx_data[WORD_W-1:HALF_W] == '0)); // R4

  AST_SINGLE_CLK_B1_LOW: assert property (@(posedge clk) disable iff (rst)
    (ddr_sel || clk_sel) |=> !bclk1); // R5

  AST_HALF_ONE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!ddr_sel && !clk_sel) |-> $onehot0({bclk0, bclk1})); // R3

  AST_HALF_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    (!ddr_sel && !clk_sel && $rose(bclk0)) |-> $fell(bclk1)); // R3

  AST_DATA_STABLE_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(bclk0) || $rose(bclk1)) |-> $stable(rx_data)); // R2

  AST_DDR_STABLE_FALL: assert property (@(posedge clk) disable iff (rst)
    (ddr_sel && $fell(bclk0)) |-> $stable(rx_data)); // R5
endmodule

bind rx_out_formatter rxfmt_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .ddr_sel(ddr_sel), .clk_sel(clk_sel),
  .rx_data(rx_data), .bclk0(bclk0), .bclk1(bclk1)
);

// File: tb/rx_out_formatter_tb.sv
module rx_out_formatter_tb;
  localparam int W  = 10;
  localparam int N  = 8;
  localparam int H  = N / 2;
  localparam int Q  = N / 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ddr_sel = 1'b0;
  logic         clk_sel = 1'b0;
  logic         word_stb = 1'b0;
  logic [W-1:0] word_in = '0;
  logic [W-1:0] rx_data;
  logic         bclk0, bclk1;

  int tests = 0;
  int failed = 0;

  // reference model state
  int           m_j;
  int           m_idx;
  bit           m_seen;
  logic [W-1:0] m_cur;
  bit           m_hb0, m_hb1;
  string        tag_d, tag_c;

  always #10 clk = ~clk;

  rx_out_formatter #(.WORD_W(W), .WORD_TICKS(N)) u_dut (
    .clk(clk), .rst(rst), .ddr_sel(ddr_sel), .clk_sel(clk_sel),
    .word_stb(word_stb), .word_in(word_in),
    .rx_data(rx_data), .bclk0(bclk0), .bclk1(bclk1)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_now();
    logic [W-1:0] ed;
    logic         e0, e1;
    if (ddr_sel) begin
      ed = '0;
      ed[4:0] = (m_j < H) ? m_cur[4:0] : m_cur[9:5];
      e0 = m_seen && (m_j >= Q) && (m_j < 3 * Q);
      e1 = 1'b0;
    end else if (clk_sel) begin
      ed = m_cur;
      e0 = m_seen && (m_j >= H);
      e1 = 1'b0;
    end else begin
      ed = m_cur;
      e0 = m_hb0;
      e1 = m_hb1;
    end
    chk({tag_d, " data"}, rx_data, ed);
    chk({tag_c, " clocks"}, {8'b0, bclk1, bclk0}, {8'b0, e1, e0});
  endtask

  // called at a negedge: check, drive, clock, update model, back to negedge
  task automatic tick(bit stb, logic [W-1:0] w);
    check_now();
    word_stb = stb;
    word_in  = w;
    @(posedge clk);
    if (stb) begin
      m_j = 0; m_cur = w; m_idx++; m_seen = 1;
    end else if (m_seen && m_j < N - 1) begin
      m_j++;
    end
    if (!ddr_sel && !clk_sel && m_seen && m_j >= H) begin
      m_hb1 = (m_idx % 2 == 0);
      m_hb0 = !m_hb1;
    end
    @(negedge clk);
  endtask

  task automatic do_reset(bit d, bit c);
    ddr_sel = d; clk_sel = c;
    word_stb = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_j = N - 1; m_idx = -1; m_seen = 0; m_cur = '0; m_hb0 = 0; m_hb1 = 0;
    tag_d = "R1"; tag_c = "R1";
  endtask

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      bit d = cfg[1];
      bit c = cfg[0];
      string tm = d ? "R4" : (c ? "R2" : "R3");
      string tc = d ? "R5" : (c ? "R2" : "R3");
      do_reset(d, c);
      for (int i = 0; i < 3; i++) tick(1'b0, '0);        // R1 idle after reset
      for (int k = 0; k < 7; k++) begin
        logic [W-1:0] w;
        int gap;
        w   = (k == 4) ? 10'h3e0 : W'((k * 317 + cfg * 53 + 5) % 1024);
        gap = (k == 3 || k == 5) ? N + 5 : N;             // R6 stretched words
        tick(1'b1, w);
        tag_d = (gap > N) ? {"R6/", tm} : tm;
        tag_c = (gap > N) ? {"R6/", tc} : tc;
        for (int i = 1; i < gap; i++) tick(1'b0, '0);
      end
      check_now();
    end
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failed++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule